// File: doc/BRIEF.md
# Supply undervoltage supervisor with restart hold-off

This block watches the comparator flags of three supplies (a main input supply and two regulated rails) and turns them into an active-low undervoltage error and a switch-disable signal for the output drivers. Each flag is high while its supply is above its threshold. The thresholds and their hysteresis sit in the analog comparators and are not part of this block.

An undervoltage must persist for a short confirmation interval before the error is raised and the drivers are turned off. Brief dips shorter than that interval are ignored. Once every supply is good again, the error is released and the drivers are re-enabled only after a much longer hold-off. Any new dip during the hold-off restarts it. Reset puts the block into the fault state, so the same hold-off also keeps the drivers off at power-up while the supplies settle. A separate error input from other protection logic, such as overload or overtemperature, also forces the drivers off, but it leaves the undervoltage error alone.

The flags are synchronised to the clock first. Both delays are parameters counted in clock cycles.

Top module: `supv_uv_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `uv_err_n_o` is 0 and `sw_off_o` is 1.
- R2: Each bit of `rail_ok_i` means 1 = supply good and 0 = undervoltage. If any single bit is 0 at CONFIRM_CYC consecutive sampling edges, starting at edge n, `uv_err_n_o` goes to 0 after edge n+SYNC_STAGES+CONFIRM_CYC-1.
- R3: An undervoltage that lasts fewer than CONFIRM_CYC sampling edges does not raise the error. The confirmation count restarts from zero at every good sample, so two short dips separated by one good sample do not raise the error either.
- R4: While the error is asserted, if all bits are 1 at HOLD_CYC consecutive sampling edges starting at edge m, `uv_err_n_o` returns to 1 after edge m+SYNC_STAGES+HOLD_CYC-1.
- R5: Any undervoltage sample during the hold-off restarts the hold-off count. Release then needs HOLD_CYC consecutive good samples counted from the first good sample after the dip.
- R6: Power-up follows R4. If all supplies are good from the first edge after reset, the error is released after edge SYNC_STAGES+HOLD_CYC, counting that first edge as edge 1.
- R7: `sw_off_o` is 1 whenever `uv_err_n_o` is 0.
- R8: `ext_fault_i` = 1 sampled at an edge sets `sw_off_o` to 1 after that edge. It has no effect on `uv_err_n_o`. With no undervoltage fault, `sw_off_o` follows `ext_fault_i` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_ok_i | input | N_RAILS | Supply comparator flags, 1 = good (asynchronous) |
| ext_fault_i | input | 1 | Other protection error, 1 = fault |
| uv_err_n_o | output | 1 | Undervoltage error, active low, registered |
| sw_off_o | output | 1 | Driver disable, 1 = outputs off or high impedance, registered |

## Verification
Every result of this block is tied to a fixed edge count. An undervoltage sampled at edge n shows on the error after edge n+SYNC_STAGES+CONFIRM_CYC-1. A good run starting at edge m releases the error after edge m+SYNC_STAGES+HOLD_CYC-1. The external fault reaches the disable output one edge after it is sampled. Inputs change on falling edges and outputs are read on falling edges, so each edge count maps directly onto a number of half-cycle-offset steps. The directed checks read the outputs one step before and one step at the due edge, which pins both the latency and the restart of the counts. A cycle-by-cycle reference model built from these latencies follows the random phase.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_FAULT = 1'b1
  } supv_state_e;

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[gi] <= '0;
        else     stg[gi] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[gi] <= '0;
        else     stg[gi] <= stg[gi-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/supv_run_timer.sv
module supv_run_timer #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic cond_i,
  output logic done_o
);

  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = arm_i && cond_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !arm_i || !cond_i || done_o) cnt_q <= '0;
    else                                   cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/supv_uv_top.sv
module supv_uv_top
  import supv_pkg::*;
#(
  parameter int N_RAILS     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int CONFIRM_CYC = 10000,
  parameter int HOLD_CYC    = 10000000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_RAILS-1:0] rail_ok_i,
  input  logic               ext_fault_i,
  output logic               uv_err_n_o,
  output logic               sw_off_o
);

  logic [N_RAILS-1:0] rail_sync;
  logic               low_seen;
  logic               good_seen;
  logic               confirm_hit;
  logic               hold_done;
  supv_state_e        state_q;
  supv_state_e        state_d;

  supv_sync #(.WIDTH(N_RAILS), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (rail_ok_i),
    .q_o (rail_sync)
  );

  assign good_seen = &rail_sync;
  assign low_seen  = ~good_seen;

  supv_run_timer #(.LEN(CONFIRM_CYC)) confirm_i (
    .clk    (clk),
    .rst    (rst),
    .arm_i  (state_q == ST_RUN),
    .cond_i (low_seen),
    .done_o (confirm_hit)
  );

  supv_run_timer #(.LEN(HOLD_CYC)) hold_i (
    .clk    (clk),
    .rst    (rst),
    .arm_i  (state_q == ST_FAULT),
    .cond_i (good_seen),
    .done_o (hold_done)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:   if (confirm_hit) state_d = ST_FAULT;
      ST_FAULT: if (hold_done)   state_d = ST_RUN;
      default:  state_d = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_FAULT;
      uv_err_n_o <= 1'b0;
      sw_off_o   <= 1'b1;
    end else begin
      state_q    <= state_d;
      uv_err_n_o <= (state_d == ST_RUN);
      sw_off_o   <= (state_d == ST_FAULT) || ext_fault_i;
    end
  end

endmodule

// File: rtl/supv_uv_chk.sv
module supv_uv_chk (
  input logic clk,
  input logic rst,
  input logic ext_fault_i,
  input logic uv_err_n_o,
  input logic sw_off_o,
  input logic low_seen,
  input logic good_seen
);

  assert_err_falls_on_low_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(uv_err_n_o) |-> $past(low_seen));

  assert_release_on_good_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(uv_err_n_o) |-> $past(good_seen));

  assert_off_during_err_R7: assert property (@(posedge clk) disable iff (rst)
    !uv_err_n_o |-> sw_off_o);

  assert_ext_forces_off_R8: assert property (@(posedge clk) disable iff (rst)
    $past(ext_fault_i) |-> sw_off_o);

  assert_enable_needs_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(sw_off_o) |-> (uv_err_n_o && !$past(ext_fault_i)));

endmodule

bind supv_uv_top supv_uv_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .ext_fault_i (ext_fault_i),
  .uv_err_n_o  (uv_err_n_o),
  .sw_off_o    (sw_off_o),
  .low_seen    (low_seen),
  .good_seen   (good_seen)
);

// File: tb/supv_uv_top_tb_top.sv
`timescale 1ns/100ps
module supv_uv_top_tb_top;

  localparam int S = 2;
  localparam int C = 8;
  localparam int H = 30;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] rail = 3'b111;
  logic       ext = 1'b0;
  logic       uv_err_n;
  logic       sw_off;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  bit model_on = 0;
  string phase = "R2";

  always #2.5 clk = ~clk;

  supv_uv_top #(.N_RAILS(3), .SYNC_STAGES(S), .CONFIRM_CYC(C), .HOLD_CYC(H)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .rail_ok_i   (rail),
    .ext_fault_i (ext),
    .uv_err_n_o  (uv_err_n),
    .sw_off_o    (sw_off)
  );

  // Reference model from the latency rules in the requirements
  logic [2:0] pipe [S];
  bit m_fault;
  int cc, hc;
  bit exp_err_n, exp_off;

  function automatic bit next_fault(bit f, bit low, int c_cnt, int h_cnt);
    if (!f) return low && (c_cnt == C - 1);
    return !(!low && (h_cnt == H - 1));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < S; i++) pipe[i] = '0;
      m_fault = 1; cc = 0; hc = 0;
      exp_err_n = 0; exp_off = 1;
    end else begin
      bit low, nf;
      low = ~&pipe[S-1];
      for (int i = S - 1; i > 0; i--) pipe[i] = pipe[i-1];
      pipe[0] = rail;
      nf = next_fault(m_fault, low, cc, hc);
      if (!m_fault) begin
        cc = (low && !nf) ? cc + 1 : 0;
        hc = 0;
      end else begin
        hc = (!low && nf) ? hc + 1 : 0;
        cc = 0;
      end
      m_fault = nf;
      exp_err_n = !nf;
      exp_off = nf || ext;
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && !rst) begin
      check(phase, "model uv_err_n", uv_err_n, exp_err_n);
      check(phase, "model sw_off", sw_off, exp_off);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    step(3);
    // R1: reset state
    check("R1", "uv_err_n in reset", uv_err_n, 1'b0);
    check("R1", "sw_off in reset", sw_off, 1'b1);
    rst = 1'b0;
    model_on = 1;
    phase = "R6";
    step(1);
    check("R1", "uv_err_n after reset", uv_err_n, 1'b0);
    check("R1", "sw_off after reset", sw_off, 1'b1);
    // R6: power-up hold-off
    step(S + H - 2);
    check("R6", "still held before due edge", uv_err_n, 1'b0);
    check("R7", "off while held", sw_off, 1'b1);
    step(1);
    check("R6", "released at due edge", uv_err_n, 1'b1);
    check("R6", "drivers on after hold-off", sw_off, 1'b0);

    // R2: each rail alone confirms an undervoltage
    for (int r = 0; r < 3; r++) begin
      phase = "R2";
      rail = 3'b111 & ~(3'b001 << r);
      step(S + C - 1);
      check("R2", "not yet confirmed", uv_err_n, 1'b1);
      step(1);
      check("R2", "confirmed on rail", uv_err_n, 1'b0);
      check("R7", "off with error", sw_off, 1'b1);
      phase = "R4";
      rail = 3'b111;
      step(S + H - 1);
      check("R4", "held before due edge", uv_err_n, 1'b0);
      step(1);
      check("R4", "released at due edge", uv_err_n, 1'b1);
    end

    // R3: short dips and restart of confirmation
    phase = "R3";
    rail = 3'b101; step(C - 1);
    rail = 3'b111; step(1);
    rail = 3'b011; step(C - 1);
    rail = 3'b111; step(S + C + 2);
    check("R3", "short dips ignored", uv_err_n, 1'b1);
    check("R3", "drivers stay on", sw_off, 1'b0);

    // R5: dip during hold-off restarts it
    phase = "R5";
    rail = 3'b110; step(C + S + 1);
    check("R5", "fault entered", uv_err_n, 1'b0);
    rail = 3'b111; step(H / 2);
    rail = 3'b110; step(1);
    rail = 3'b111;
    step(S + H - 1);
    check("R5", "hold-off restarted", uv_err_n, 1'b0);
    step(1);
    check("R5", "released after full restart", uv_err_n, 1'b1);

    // R8: external fault
    phase = "R8";
    ext = 1'b1; step(1);
    check("R8", "ext forces off", sw_off, 1'b1);
    check("R8", "ext leaves uv error", uv_err_n, 1'b1);
    ext = 1'b0; step(1);
    check("R8", "drivers back on", sw_off, 1'b0);

    // Random phase against the model
    phase = "R2";
    for (int seg = 0; seg < 150; seg++) begin
      int len;
      len = 1 + int'($urandom_range(0, 45));
      rail = ($urandom_range(0, 2) == 0) ? 3'($urandom_range(0, 7)) : 3'b111;
      ext = ($urandom_range(0, 9) == 0);
      step(len);
    end
    rail = 3'b111; ext = 1'b0;
    step(S + H + 2);
    check("R4", "final release", uv_err_n, 1'b1);
    finish_run();
  end

endmodule